// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters behind one byte-wide register bus with a 2-bit address. Addresses 0 to 2 reach the count of channels 0 to 2. Address 3 takes control words, which set up one channel at a time or freeze its count for reading. Each channel has its own count-enable input, `ch_tick`: a pulse that lasts one `clk` cycle and stands for one edge of that channel's input clock. Each channel also has one output.

A channel runs in one of two ways. As a square-wave rate generator it splits each period of N ticks into a high half and a low half. As a software-triggered strobe it gives a single low pulse, one tick long, N ticks after the count is loaded. Counting is either plain binary or four-digit decimal (BCD). Loads and reads move the low byte only, the high byte only, or the low byte first and then the high byte.

Software writes a control word first and then the count bytes. Before a stable read of a running channel, it issues a latch command.

Top module: `pit3_timer`

## Requirements
- R1: A write to address 3 is a control word. Bits [7:6] select the channel. Bits [5:4] set the access type. Bits [3:1] equal to 011 select square-wave mode, and any other value selects strobe mode. Bit 0 set selects BCD counting. A select value of 3 is ignored and no channel changes.
- R2: Access type 01 moves the high byte only, and a load sets the low byte to 00h. Access type 10 moves the low byte only, and a load sets the high byte to 00h. Access type 11 moves the low byte first and then the high byte. A read with no latch pending returns the live count.
- R3: A loaded count of zero acts as the largest count. One tick after loading zero, the count reads FFFFh in binary or 9999h in BCD.
- R4: In BCD each 4-bit digit counts down in decimal, so a loaded 0010h reads 0009h after one tick.
- R5: In square-wave mode with count N, the output is high for (N+1)/2 ticks and low for N/2 ticks, rounded down, and this repeats. The output changes only on a tick.
- R6: In square-wave mode, a count loaded while the channel runs takes effect when the current period ends, at the next rising edge of the output.
- R7: In strobe mode, the output is high once the control word is written and stays high until a count is loaded. N ticks after the load it goes low for exactly one tick and then returns high. Each load gives one pulse.
- R8: In strobe mode with two-byte access, writing the first byte halts the count. Writing the second byte starts the new count.
- R9: Access type 00 latches the chosen channel's count. The next reads return the latched value in the programmed byte order while the count goes on. A second latch command before that read sequence finishes is ignored.
- R10: A control word for a channel clears that channel's byte pointers and any pending latch, drives its output high, and halts it until a count is loaded.
- R11: After reset every output is high, every channel is idle with count 0000h, and every channel uses two-byte binary access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; advances the read byte pointer |
| bus_addr | input | 2 | 0 to 2: channel count, 3: control word |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed channel, valid in the cycle of the read |
| ch_tick | input | 3 | Count-enable pulse for each channel |
| ch_out | output | 3 | Output of each channel |

## Verification
The hardest case to reach is a square-wave reload that must wait. The new count has to arrive in the middle of a period, and the next rise of the output must prove the old period ran to its end. The stimulus loads 5, gives two ticks, writes 4 and keeps ticking. It then checks the output at each tick and latches and reads the count just after the rise to see 0004h. A similar case checks the halt in strobe mode. After the first byte of a reload and several more ticks, a latched read must still show the count from before the halt.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int DIGITS  = CNT_W / 4;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_MSB   = 2'b01,
        ACC_LSB   = 2'b10,
        ACC_BOTH  = 2'b11
    } access_e;

    typedef struct packed {
        logic [1:0] sel;
        access_e    acc;
        logic [2:0] mode;
        logic       bcd;
    } ctl_word_t;

    // one step down, digit-wise in decimal when bcd is set
    function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic borrow;
        if (!bcd) return v - CNT_W'(1);
        r = v;
        borrow = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (borrow) begin
                if (v[i*4 +: 4] == 4'd0) r[i*4 +: 4] = 4'd9;
                else begin
                    r[i*4 +: 4] = v[i*4 +: 4] - 4'd1;
                    borrow = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // numeric length of a count, zero meaning the full range
    function automatic logic [CNT_W:0] count_val(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W:0] acc;
        logic [CNT_W:0] full;
        if (!bcd) begin
            if (v == '0) return (CNT_W+1)'(1) << CNT_W;
            return {1'b0, v};
        end
        full = (CNT_W+1)'(1);
        acc  = '0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            acc  = acc * (CNT_W+1)'(10) + (CNT_W+1)'(v[i*4 +: 4]);
            full = full * (CNT_W+1)'(10);
        end
        if (v == '0) return full;
        return acc;
    endfunction
endpackage

// File: rtl/pit_bus_dec.sv
module pit_bus_dec
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [BYTE_W-1:0]    wdata_i,
    output logic [NUM_CH-1:0]    ctl_wr_o,
    output logic [NUM_CH-1:0]    latch_o,
    output logic [NUM_CH-1:0]    data_wr_o,
    output logic [NUM_CH-1:0]    data_rd_o,
    output access_e              ctl_acc_o,
    output logic                 ctl_sqw_o,
    output logic                 ctl_bcd_o
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

    ctl_word_t cw;
    logic      cw_hit;

    assign cw        = ctl_word_t'(wdata_i);
    assign cw_hit    = wr_en_i && (addr_i == CTL_ADDR);
    assign ctl_acc_o = cw.acc;
    assign ctl_sqw_o = (cw.mode == 3'b011);
    assign ctl_bcd_o = cw.bcd;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign ctl_wr_o[g]  = cw_hit && (cw.sel == 2'(g)) && (cw.acc != ACC_LATCH);
        assign latch_o[g]   = cw_hit && (cw.sel == 2'(g)) && (cw.acc == ACC_LATCH);
        assign data_wr_o[g] = wr_en_i && (addr_i == ADDR_W'(g));
        assign data_rd_o[g] = rd_en_i && (addr_i == ADDR_W'(g));
    end

    // R1: one control word reaches at most one channel
    a_r1_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl_wr_o, latch_o}));
endmodule

// File: rtl/pit_chan.sv
module pit_chan
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr_i,
    input  access_e           ctl_acc_i,
    input  logic              ctl_sqw_i,
    input  logic              ctl_bcd_i,
    input  logic              latch_i,
    input  logic              data_wr_i,
    input  logic              data_rd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              tick_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              tout_o
);
    access_e            acc_q;
    logic               bcd_q, sqw_q;
    logic [CNT_W-1:0]   cnt_q, n_act_q, n_new_q, latch_q;
    logic [BYTE_W-1:0]  lsb_q;
    logic               wr_hi_q, rd_hi_q, latched_q, run_q, pend_q, strobe_q;
    logic [CNT_W-1:0]   ld_val, rd_src;

    always_comb begin
        case (acc_q)
            ACC_MSB: ld_val = {wdata_i, {BYTE_W{1'b0}}};
            ACC_LSB: ld_val = {{BYTE_W{1'b0}}, wdata_i};
            default: ld_val = {wdata_i, lsb_q};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= ACC_BOTH; bcd_q <= 1'b0; sqw_q <= 1'b0;
            cnt_q <= '0; n_act_q <= '0; n_new_q <= '0; latch_q <= '0; lsb_q <= '0;
            wr_hi_q <= 1'b0; rd_hi_q <= 1'b0; latched_q <= 1'b0;
            run_q <= 1'b0; pend_q <= 1'b0; strobe_q <= 1'b0;
        end else if (ctl_wr_i) begin
            acc_q <= ctl_acc_i; bcd_q <= ctl_bcd_i; sqw_q <= ctl_sqw_i;
            wr_hi_q <= 1'b0; rd_hi_q <= 1'b0; latched_q <= 1'b0;
            run_q <= 1'b0; pend_q <= 1'b0; strobe_q <= 1'b0;
        end else begin
            if (latch_i && !latched_q) begin
                latched_q <= 1'b1;
                latch_q   <= cnt_q;
            end
            if (data_rd_i) begin
                if (acc_q == ACC_BOTH) rd_hi_q <= !rd_hi_q;
                if (latched_q && (acc_q != ACC_BOTH || rd_hi_q)) latched_q <= 1'b0;
            end
            if (tick_i && strobe_q) strobe_q <= 1'b0;
            if (tick_i && run_q) begin
                if (cnt_q == CNT_W'(1)) begin
                    if (sqw_q) begin
                        cnt_q   <= pend_q ? n_new_q : n_act_q;
                        n_act_q <= pend_q ? n_new_q : n_act_q;
                        pend_q  <= 1'b0;
                    end else begin
                        cnt_q    <= '0;
                        run_q    <= 1'b0;
                        strobe_q <= 1'b1;
                    end
                end else begin
                    cnt_q <= count_dec(cnt_q, bcd_q);
                end
            end
            if (data_wr_i) begin
                if (acc_q == ACC_BOTH && !wr_hi_q) begin
                    lsb_q   <= wdata_i;
                    wr_hi_q <= 1'b1;
                    if (!sqw_q) begin
                        run_q    <= 1'b0;
                        strobe_q <= 1'b0;
                    end
                end else begin
                    wr_hi_q <= 1'b0;
                    if (sqw_q && run_q) begin
                        n_new_q <= ld_val;
                        pend_q  <= 1'b1;
                    end else begin
                        cnt_q    <= ld_val;
                        n_act_q  <= ld_val;
                        run_q    <= 1'b1;
                        pend_q   <= 1'b0;
                        strobe_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign rd_src = latched_q ? latch_q : cnt_q;

    always_comb begin
        case (acc_q)
            ACC_MSB: rdata_o = rd_src[CNT_W-1:BYTE_W];
            ACC_LSB: rdata_o = rd_src[BYTE_W-1:0];
            default: rdata_o = rd_hi_q ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
        endcase
    end

    assign tout_o = sqw_q ? (!run_q || (count_val(cnt_q, bcd_q) > (count_val(n_act_q, bcd_q) >> 1)))
                          : !strobe_q;

    // R7: a strobe pulse only begins on a tick
    a_r7_strobe_on_tick: assert property (@(posedge clk) disable iff (rst)
        (!sqw_q && $fell(tout_o)) |-> $past(tick_i));
    // R5: with no tick and no bus write the square wave holds its level
    a_r5_wave_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (sqw_q && !tick_i && !data_wr_i && !ctl_wr_i) |=> $stable(tout_o));
    // R10: a control word leaves the channel idle with its pointers cleared
    a_r10_ctl_idles: assert property (@(posedge clk) disable iff (rst)
        ctl_wr_i |=> (tout_o && !run_q && !wr_hi_q && !rd_hi_q && !latched_q));
    // R8: the first of two bytes halts a strobe-mode count
    a_r8_first_byte_halts: assert property (@(posedge clk) disable iff (rst)
        (data_wr_i && !ctl_wr_i && !sqw_q && acc_q == ACC_BOTH && !wr_hi_q) |=> (!run_q && tout_o));
    // R9: a held latch value does not move until read out
    a_r9_latch_frozen: assert property (@(posedge clk) disable iff (rst)
        (latched_q && !ctl_wr_i) |=> $stable(latch_q));
endmodule

// File: rtl/pit3_timer.sv
module pit3_timer
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] ch_tick,
    output logic [NUM_CH-1:0] ch_out
);
    logic [NUM_CH-1:0] ctl_wr, latch, data_wr, data_rd;
    access_e           ctl_acc;
    logic              ctl_sqw, ctl_bcd;
    logic [BYTE_W-1:0] ch_rdata [NUM_CH];

    pit_bus_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst(rst),
        .wr_en_i(bus_wr), .rd_en_i(bus_rd), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .ctl_wr_o(ctl_wr), .latch_o(latch), .data_wr_o(data_wr), .data_rd_o(data_rd),
        .ctl_acc_o(ctl_acc), .ctl_sqw_o(ctl_sqw), .ctl_bcd_o(ctl_bcd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pit_chan u_ch (
            .clk(clk), .rst(rst),
            .ctl_wr_i(ctl_wr[g]), .ctl_acc_i(ctl_acc), .ctl_sqw_i(ctl_sqw), .ctl_bcd_i(ctl_bcd),
            .latch_i(latch[g]), .data_wr_i(data_wr[g]), .data_rd_i(data_rd[g]),
            .wdata_i(bus_wdata), .tick_i(ch_tick[g]),
            .rdata_o(ch_rdata[g]), .tout_o(ch_out[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (bus_addr == ADDR_W'(i)) bus_rdata = ch_rdata[i];
    end
endmodule

// File: tb/test_pit3_timer.sv
module test_pit3_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [2:0] ch_tick = '0;
    logic [7:0] bus_rdata;
    logic [2:0] ch_out;
    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    pit3_timer i_pit3_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_tick(ch_tick), .ch_out(ch_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: compare each read against the scoreboard
    always @(negedge clk) begin
        if (bus_rd) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL bench: read with empty scoreboard, actual %h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: read actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic tk(input int ch);
        @(posedge clk); #1;
        ch_tick[ch] = 1'b1;
        @(posedge clk); #1;
        ch_tick = '0;
    endtask

    task automatic chk_out(input int ch, input logic e, input string tag);
        n_chk++;
        if (ch_out[ch] !== e) begin
            n_fail++;
            $display("FAIL %s: ch_out[%0d] actual %b expected %b", tag, ch, ch_out[ch], e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R11: reset state
        for (int c = 0; c < 3; c++) chk_out(c, 1'b1, "R11 reset output");
        rd(0, 8'h00, "R11 reset count low");
        rd(0, 8'h00, "R11 reset count high");

        // R5: odd count 5, square-wave binary on channel 0
        wr(3, 8'h36); wr(0, 8'h05); wr(0, 8'h00);
        chk_out(0, 1'b1, "R5 start high");
        for (int k = 1; k <= 10; k++) begin
            tk(0);
            chk_out(0, (5 - (k % 5)) > 2, "R5 odd count wave");
        end
        // R5: even count 4 on channel 1
        wr(3, 8'h76); wr(1, 8'h04); wr(1, 8'h00);
        for (int k = 1; k <= 8; k++) begin
            tk(1);
            chk_out(1, (4 - (k % 4)) > 2, "R5 even count wave");
        end

        // R7: strobe mode on channel 2
        wr(3, 8'hB8);
        chk_out(2, 1'b1, "R7 high after control word");
        wr(2, 8'h03); wr(2, 8'h00);
        tk(2); chk_out(2, 1'b1, "R7 tick 1");
        tk(2); chk_out(2, 1'b1, "R7 tick 2");
        tk(2); chk_out(2, 1'b0, "R7 terminal strobe");
        tk(2); chk_out(2, 1'b1, "R7 strobe one tick");
        tk(2); chk_out(2, 1'b1, "R7 single pulse");

        // R8: first byte halts, second starts
        wr(3, 8'hB8); wr(2, 8'h03); wr(2, 8'h00);
        tk(2);
        wr(2, 8'h05);
        tk(2); tk(2); tk(2);
        wr(3, 8'h80);
        rd(2, 8'h02, "R8 halted count low");
        rd(2, 8'h00, "R8 halted count high");
        chk_out(2, 1'b1, "R8 halted output");
        wr(2, 8'h00);
        for (int k = 1; k <= 4; k++) begin
            tk(2); chk_out(2, 1'b1, "R8 new count running");
        end
        tk(2); chk_out(2, 1'b0, "R8 new count strobe");

        // R9: latch, count moves on, second latch ignored
        wr(3, 8'h00);
        tk(0); tk(0);
        wr(3, 8'h00);
        tk(0);
        rd(0, 8'h05, "R9 latched low");
        rd(0, 8'h00, "R9 latched high");
        wr(3, 8'h00);
        rd(0, 8'h02, "R9 fresh latch low");
        rd(0, 8'h00, "R9 fresh latch high");

        // R6 and R10: reload mid-period waits for period end
        wr(3, 8'h36); wr(0, 8'h05); wr(0, 8'h00);
        chk_out(0, 1'b1, "R10 control word then load");
        tk(0); tk(0);
        wr(0, 8'h04); wr(0, 8'h00);
        chk_out(0, 1'b1, "R6 old period high");
        tk(0); chk_out(0, 1'b0, "R6 old period low 1");
        tk(0); chk_out(0, 1'b0, "R6 old period low 2");
        tk(0); chk_out(0, 1'b1, "R6 new period rise");
        wr(3, 8'h00);
        rd(0, 8'h04, "R6 new count applied low");
        rd(0, 8'h00, "R6 new count applied high");
        tk(0); chk_out(0, 1'b1, "R6 new period high");
        tk(0); chk_out(0, 1'b0, "R6 new period low 1");
        tk(0); chk_out(0, 1'b0, "R6 new period low 2");
        tk(0); chk_out(0, 1'b1, "R6 new period repeat");

        // R4: BCD decimal step on channel 1
        wr(3, 8'h77); wr(1, 8'h10); wr(1, 8'h00);
        tk(1);
        wr(3, 8'h40);
        rd(1, 8'h09, "R4 bcd low");
        rd(1, 8'h00, "R4 bcd high");
        chk_out(1, 1'b1, "R4 bcd wave high");
        tk(1); tk(1); tk(1);
        chk_out(1, 1'b1, "R4 bcd wave still high");
        tk(1);
        chk_out(1, 1'b0, "R4 bcd wave low at half");

        // R3: zero means full range, BCD then binary
        wr(3, 8'h79); wr(1, 8'h00); wr(1, 8'h00);
        tk(1);
        wr(3, 8'h40);
        rd(1, 8'h99, "R3 bcd zero low");
        rd(1, 8'h99, "R3 bcd zero high");
        wr(3, 8'h78); wr(1, 8'h00); wr(1, 8'h00);
        tk(1);
        wr(3, 8'h40);
        rd(1, 8'hFF, "R3 binary zero low");
        rd(1, 8'hFF, "R3 binary zero high");

        // R2: low byte only, then high byte only
        wr(3, 8'h26); wr(0, 8'h04);
        rd(0, 8'h04, "R2 lsb only live");
        tk(0);
        rd(0, 8'h03, "R2 lsb only after tick");
        chk_out(0, 1'b1, "R2 lsb count wave");
        tk(0);
        chk_out(0, 1'b0, "R2 lsb count wave low");
        wr(3, 8'h16); wr(0, 8'h01);
        rd(0, 8'h01, "R2 msb only live");
        tk(0);
        rd(0, 8'h00, "R2 msb only after tick");
        chk_out(0, 1'b1, "R2 msb count wave");

        // R1: select 3 is ignored
        wr(3, 8'hE8);
        rd(0, 8'h00, "R1 illegal select ignored");
        chk_out(0, 1'b1, "R1 illegal select output");

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule